// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Master with Fault Tracking

This block is a single-master controller for a two-wire open-drain serial bus (I2C). A host issues one command at a time: a start condition, a stop condition, a byte transmit with acknowledge sampling, a byte receive with a host-supplied acknowledge, a line-coupling self-test, or an error clear. The block drives each line through an active-low output enable and reads both lines back through a two-flop synchronizer, so that every drive step can be compared with the real line level.

All bus phases are measured in a base tick of `TICK_DIV` clock cycles, and each phase lasts either 3 or 6 ticks. With the default setting at a 200 MHz clock one tick is 1 us, which keeps a bit well below 100 kHz. When a line does not follow what the block drives, or a slave does not acknowledge, a fault code is recorded; only the first fault since the last clear is kept.

The controller is a single state machine. States: `S_IDLE`; start `S_ST_SDA`, `S_ST_SCL`, `S_ST_HOLD`, `S_ST_SDALO`, `S_ST_SCLLO`; stop `S_SP_SDA`, `S_SP_SCL`, `S_SP_HOLD`, `S_SP_REL`, `S_SP_END`; bit transmit `S_TX_SDA`, `S_TX_SET`, `S_TX_HI1`, `S_TX_HI2`, `S_TX_LO`; bit receive `S_RX_SET`, `S_RX_HI1`, `S_RX_HI2`, `S_RX_LO`; self-test `S_TS_A`, `S_TS_B`. Transitions: an accepted command leaves `S_IDLE` for the first state of its sequence; every other state moves on when its phase timer expires; `S_TX_LO` goes to the next transmit bit, to `S_RX_SET` for the acknowledge, or to `S_IDLE`; `S_RX_LO` goes to the next receive bit, to the acknowledge transmit, or to `S_IDLE`; `S_SP_END` goes to `S_TS_A` during the first stop of a self-test and to `S_IDLE` otherwise; `S_TS_A` and `S_TS_B` go on when their line check passes and to `S_IDLE` when it fails.

Top module: `i2c_fault_master`

## Requirements
- R1: After reset both output enables are 0 (lines released), `busy`, `done`, `bus_ok` and `err_code` are 0.
- R2: A command is taken only when `cmd_valid` is high while `busy` is low; codes are 1 start, 2 stop, 3 write, 4 read, 5 self-test, 6 clear; codes 0 and 7, and any command presented while busy, have no effect on the lines or on busy.
- R3: A start releases SDA, releases SCL, drives SDA low 6 ticks after the SCL check and drives SCL low 6 ticks after SDA falls; afterwards both enables stay 1.
- R4: A stop drives SDA low, releases SCL and releases SDA 9 ticks after SCL rises; afterwards both enables are 0; if SDA reads low 3 ticks after its release, code 4 is recorded.
- R5: A write sends `wr_data` MSB first, one bit per SCL high period, then samples SDA in a ninth bit; `ack_out` takes that sample (1 = not acknowledged) and a sample of 1 records code 3.
- R6: A read collects 8 bits MSB first into `rd_data` and then drives `ack_in` as a ninth bit (0 drives SDA low).
- R7: A transmitted bit holds SCL released for 9 ticks; a received bit holds it released for 6 ticks.
- R8: If SCL reads low 3 ticks after the block releases it, code 1 is recorded.
- R9: If SDA reads low 3 ticks after the block releases it to send a 1, code 2 is recorded.
- R10: `err_code` keeps the first nonzero code; later faults leave it unchanged; clear (and self-test start) sets it to 0.
- R11: Self-test performs a stop, then expects SCL low with SDA high while driving SCL only, then SCL high with SDA low while driving SDA only; `bus_ok` is 1 only if both checks pass, after which a final stop releases both lines.
- R12: `busy` is high from the cycle after acceptance until the sequence ends; `done` is a one-cycle pulse in the first cycle with `busy` low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 3 | Command code |
| wr_data | input | 8 | Byte to transmit |
| ack_in | input | 1 | Acknowledge bit to send after a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last received byte |
| ack_out | output | 1 | Acknowledge sampled after a write |
| err_code | output | 3 | First recorded fault code |
| bus_ok | output | 1 | Self-test passed |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The assertions watch on every cycle that the fault code never changes once set except through a clear or self-test, that the line enables do not move while the block is idle, and that busy and the done pulse follow the command handshake. Phase lengths, bit order, acknowledge handling, each fault cause and the outcome of the self-test depend on what the lines do, so only the bench scenarios, with their slave model and forced-low lines, can show them.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_START = 3'd1,
        CMD_STOP  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_READ  = 3'd4,
        CMD_TEST  = 3'd5,
        CMD_CLEAR = 3'd6,
        CMD_RSVD  = 3'd7
    } cmd_e;

    localparam logic [2:0] ERR_NONE     = 3'd0;
    localparam logic [2:0] ERR_SCL_HELD = 3'd1;
    localparam logic [2:0] ERR_SDA_HELD = 3'd2;
    localparam logic [2:0] ERR_NO_ACK   = 3'd3;
    localparam logic [2:0] ERR_STOP_SDA = 3'd4;

    localparam int         UNIT_W  = 3;
    localparam logic [2:0] U_ZERO  = 3'd0;
    localparam logic [2:0] U_SHORT = 3'd3;
    localparam logic [2:0] U_LONG  = 3'd6;

    typedef enum logic [1:0] {
        OP_BUS  = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2,
        OP_TEST = 2'd3
    } op_e;

    typedef enum logic [4:0] {
        S_IDLE, S_ST_SDA, S_ST_SCL, S_ST_HOLD, S_ST_SDALO, S_ST_SCLLO,
        S_SP_SDA, S_SP_SCL, S_SP_HOLD, S_SP_REL, S_SP_END,
        S_TX_SDA, S_TX_SET, S_TX_HI1, S_TX_HI2, S_TX_LO,
        S_RX_SET, S_RX_HI1, S_RX_HI2, S_RX_LO,
        S_TS_A, S_TS_B
    } st_e;

    function automatic logic [2:0] units_of(st_e s);
        logic [2:0] u;
        unique case (s)
            S_IDLE:                                  u = U_ZERO;
            S_ST_SDA, S_ST_SCL:                      u = U_SHORT;
            S_SP_SDA, S_SP_SCL, S_SP_REL, S_SP_END:  u = U_SHORT;
            S_TX_SDA, S_TX_HI1:                      u = U_SHORT;
            S_RX_HI1, S_RX_HI2:                      u = U_SHORT;
            S_TS_A, S_TS_B:                          u = U_SHORT;
            default:                                 u = U_LONG;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= '1;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
    parameter int DIV = 200,
    parameter int UW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [UW-1:0] units,
    output logic          expire
);
    localparam int            PW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PMAX = PW'(DIV - 1);

    logic [PW-1:0] pre;
    logic [UW-1:0] left;
    logic          run;

    assign expire = run && (pre == PMAX) && (left == UW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre  <= '0;
            left <= '0;
            run  <= 1'b0;
        end else if (start) begin
            pre  <= '0;
            left <= units;
            run  <= (units != '0);
        end else if (run) begin
            if (pre == PMAX) begin
                pre  <= '0;
                left <= left - UW'(1);
                if (left == UW'(1)) run <= 1'b0;
            end else begin
                pre <= pre + PW'(1);
            end
        end
    end
endmodule

// File: rtl/i2cm_err_latch.sv
module i2cm_err_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         set,
    input  logic [W-1:0] code,
    output logic [W-1:0] err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    err <= '0;
        else if (clr)                  err <= '0;
        else if (set && err == '0)     err <= code;
    end
endmodule

// File: rtl/i2c_fault_master.sv
module i2c_fault_master
    import i2cm_pkg::*;
#(
    parameter int TICK_DIV = 200,
    parameter int DW       = 8,
    parameter int SYNC_N   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic [DW-1:0] wr_data,
    input  logic          ack_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          ack_out,
    output logic [2:0]    err_code,
    output logic          bus_ok,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe
);
    localparam int            CW    = $clog2(DW + 1);
    localparam logic [CW-1:0] LASTB = CW'(DW - 1);

    st_e           st, nx;
    op_e           op;
    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          ackq, tst_fin, scl_park, sda_park;
    logic          expire, tm_start;
    logic [1:0]    lines_s;
    logic          scl_s, sda_s;
    logic          flag_set;
    logic [2:0]    flag_code;
    logic          acc, clr_acc, test_acc, tx_bit;

    i2cm_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    assign tm_start = (nx != st);
    i2cm_phase_timer #(.DIV(TICK_DIV), .UW(UNIT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tm_start),
        .units(units_of(nx)), .expire(expire)
    );

    assign acc      = (st == S_IDLE) && cmd_valid;
    assign clr_acc  = acc && (cmd_code == CMD_CLEAR);
    assign test_acc = acc && (cmd_code == CMD_TEST);

    i2cm_err_latch #(.W(3)) u_err (
        .clk(clk), .rst_n(rst_n), .clr(clr_acc || test_acc),
        .set(flag_set), .code(flag_code), .err(err_code)
    );

    assign tx_bit = (op == OP_WR) ? sh[DW-1] : ackq;
    assign busy   = (st != S_IDLE);

    // next state and line checks
    always_comb begin
        nx        = st;
        flag_set  = 1'b0;
        flag_code = ERR_NONE;
        unique case (st)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_code)
                        CMD_START: nx = S_ST_SDA;
                        CMD_STOP,
                        CMD_TEST:  nx = S_SP_SDA;
                        CMD_WRITE: nx = wr_data[DW-1] ? S_TX_SDA : S_TX_SET;
                        CMD_READ:  nx = S_RX_SET;
                        default:   nx = S_IDLE;
                    endcase
                end
            end
            S_ST_SDA:   if (expire) nx = S_ST_SCL;
            S_ST_SCL: begin
                if (expire) begin
                    nx = S_ST_HOLD;
                    if (!scl_s) begin flag_set = 1'b1; flag_code = ERR_SCL_HELD; end
                end
            end
            S_ST_HOLD:  if (expire) nx = S_ST_SDALO;
            S_ST_SDALO: if (expire) nx = S_ST_SCLLO;
            S_ST_SCLLO: if (expire) nx = S_IDLE;
            S_SP_SDA:   if (expire) nx = S_SP_SCL;
            S_SP_SCL: begin
                if (expire) begin
                    nx = S_SP_HOLD;
                    if (!scl_s) begin flag_set = 1'b1; flag_code = ERR_SCL_HELD; end
                end
            end
            S_SP_HOLD:  if (expire) nx = S_SP_REL;
            S_SP_REL: begin
                if (expire) begin
                    nx = S_SP_END;
                    if (!sda_s) begin flag_set = 1'b1; flag_code = ERR_STOP_SDA; end
                end
            end
            S_SP_END: begin
                if (expire) nx = (op == OP_TEST && !tst_fin) ? S_TS_A : S_IDLE;
            end
            S_TX_SDA: begin
                if (expire) begin
                    nx = S_TX_SET;
                    if (!sda_s) begin flag_set = 1'b1; flag_code = ERR_SDA_HELD; end
                end
            end
            S_TX_SET:   if (expire) nx = S_TX_HI1;
            S_TX_HI1: begin
                if (expire) begin
                    nx = S_TX_HI2;
                    if (!scl_s) begin flag_set = 1'b1; flag_code = ERR_SCL_HELD; end
                end
            end
            S_TX_HI2:   if (expire) nx = S_TX_LO;
            S_TX_LO: begin
                if (expire) begin
                    if (op == OP_WR && cnt != LASTB) nx = sh[DW-2] ? S_TX_SDA : S_TX_SET;
                    else if (op == OP_WR)            nx = S_RX_SET;
                    else                             nx = S_IDLE;
                end
            end
            S_RX_SET:   if (expire) nx = S_RX_HI1;
            S_RX_HI1: begin
                if (expire) begin
                    nx = S_RX_HI2;
                    if (!scl_s) begin flag_set = 1'b1; flag_code = ERR_SCL_HELD; end
                end
            end
            S_RX_HI2: begin
                if (expire) begin
                    nx = S_RX_LO;
                    if (op == OP_WR && sda_s) begin flag_set = 1'b1; flag_code = ERR_NO_ACK; end
                end
            end
            S_RX_LO: begin
                if (expire) begin
                    if (op == OP_WR)        nx = S_IDLE;
                    else if (cnt == LASTB)  nx = ackq ? S_TX_SDA : S_TX_SET;
                    else                    nx = S_RX_SET;
                end
            end
            S_TS_A: if (expire) nx = (!scl_s && sda_s) ? S_TS_B : S_IDLE;
            S_TS_B: if (expire) nx = (scl_s && !sda_s) ? S_SP_SDA : S_IDLE;
            default: nx = S_IDLE;
        endcase
    end

    // state register and sequence data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            op       <= OP_BUS;
            sh       <= '0;
            cnt      <= '0;
            ackq     <= 1'b0;
            tst_fin  <= 1'b0;
            scl_park <= 1'b0;
            sda_park <= 1'b0;
            rd_data  <= '0;
            ack_out  <= 1'b0;
            bus_ok   <= 1'b0;
            done     <= 1'b0;
        end else begin
            st   <= nx;
            done <= (st != S_IDLE && nx == S_IDLE) || clr_acc;
            if (acc) begin
                cnt     <= '0;
                tst_fin <= 1'b0;
                unique case (cmd_code)
                    CMD_WRITE: begin op <= OP_WR; sh <= wr_data; end
                    CMD_READ:  begin op <= OP_RD; ackq <= ack_in; end
                    CMD_TEST:  begin op <= OP_TEST; bus_ok <= 1'b0; end
                    default:   op <= OP_BUS;
                endcase
            end
            if (expire) begin
                unique case (st)
                    S_ST_SCLLO: begin scl_park <= 1'b1; sda_park <= 1'b1; end
                    S_SP_END: begin
                        if (!(op == OP_TEST && !tst_fin)) begin
                            scl_park <= 1'b0; sda_park <= 1'b0;
                        end
                    end
                    S_TX_LO: begin
                        cnt <= cnt + CW'(1);
                        if (op == OP_WR) sh <= {sh[DW-2:0], 1'b0};
                        else begin
                            rd_data  <= sh;
                            scl_park <= 1'b1;
                            sda_park <= !ackq;
                        end
                    end
                    S_RX_HI2: begin
                        if (op == OP_RD) sh <= {sh[DW-2:0], sda_s};
                        else             ack_out <= sda_s;
                    end
                    S_RX_LO: begin
                        cnt <= cnt + CW'(1);
                        if (op == OP_WR) begin scl_park <= 1'b1; sda_park <= 1'b0; end
                    end
                    S_TS_A: begin
                        if (!(!scl_s && sda_s)) begin scl_park <= 1'b0; sda_park <= 1'b0; end
                    end
                    S_TS_B: begin
                        if (scl_s && !sda_s) begin
                            bus_ok <= 1'b1; tst_fin <= 1'b1; scl_park <= 1'b0;
                        end else begin
                            scl_park <= 1'b0; sda_park <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // line drive per state (1 pulls the line low)
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (st)
            S_IDLE:               begin scl_oe = scl_park; sda_oe = sda_park; end
            S_ST_SDA:             begin scl_oe = scl_park; sda_oe = 1'b0;     end
            S_ST_SCL, S_ST_HOLD:  begin scl_oe = 1'b0;     sda_oe = 1'b0;     end
            S_ST_SDALO:           begin scl_oe = 1'b0;     sda_oe = 1'b1;     end
            S_ST_SCLLO:           begin scl_oe = 1'b1;     sda_oe = 1'b1;     end
            S_SP_SDA:             begin scl_oe = scl_park; sda_oe = 1'b1;     end
            S_SP_SCL, S_SP_HOLD:  begin scl_oe = 1'b0;     sda_oe = 1'b1;     end
            S_SP_REL, S_SP_END:   begin scl_oe = 1'b0;     sda_oe = 1'b0;     end
            S_TX_SDA:             begin scl_oe = 1'b1;     sda_oe = 1'b0;     end
            S_TX_SET, S_TX_LO:    begin scl_oe = 1'b1;     sda_oe = !tx_bit;  end
            S_TX_HI1, S_TX_HI2:   begin scl_oe = 1'b0;     sda_oe = !tx_bit;  end
            S_RX_SET, S_RX_LO:    begin scl_oe = 1'b1;     sda_oe = 1'b0;     end
            S_RX_HI1, S_RX_HI2:   begin scl_oe = 1'b0;     sda_oe = 1'b0;     end
            S_TS_A:               begin scl_oe = 1'b1;     sda_oe = 1'b0;     end
            S_TS_B:               begin scl_oe = 1'b0;     sda_oe = 1'b1;     end
            default:              begin scl_oe = 1'b0;     sda_oe = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       busy,
    input logic       done,
    input logic [2:0] err_code,
    input logic       scl_oe,
    input logic       sda_oe
);
    // R10
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != ERR_NONE && !(cmd_valid && !busy &&
            (cmd_code == CMD_CLEAR || cmd_code == CMD_TEST))) |=> $stable(err_code));

    // R10
    clear_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_code == CMD_CLEAR) |=> (err_code == ERR_NONE));

    // R2
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
endmodule

bind i2c_fault_master i2cm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .busy(busy), .done(done), .err_code(err_code),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_fault_master_test.sv
`timescale 1ns/1ps
module i2c_fault_master_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       ack_in = 1'b0;
    logic       busy, done, ack_out, bus_ok, scl_oe, sda_oe;
    logic [7:0] rd_data;
    logic [2:0] err_code;
    logic       scl_hold = 1'b0, sda_hold = 1'b0;
    logic       scl_ln, sda_ln, sda_slave;

    int total = 0, bad = 0, cyc = 0;

    // bench slave: mode 0 none, 1 receives a byte, 2 sends a byte
    int         mode = 0;
    logic [7:0] tx_byte = 8'h00;
    logic       slave_ack = 1'b0;
    logic       idx_clr = 1'b0;
    logic [3:0] bit_idx = 4'd0;
    logic [7:0] cap = 8'h00;
    logic       cap_ack = 1'b0;
    logic       scl_prev = 1'b1, sda_prev = 1'b1;
    int t_rise = 0, t_scl_fall = 0, t_sda_fall = 0, t_sda_rise = 0;
    int hi_bit0 = 0, hi_ack = 0;

    always #2.5 clk = ~clk;

    i2c_fault_master #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wr_data(wr_data), .ack_in(ack_in), .busy(busy), .done(done),
        .rd_data(rd_data), .ack_out(ack_out), .err_code(err_code),
        .bus_ok(bus_ok), .scl_in(scl_ln), .sda_in(sda_ln),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    assign sda_slave = (mode == 2 && bit_idx < 4'd8) ? !tx_byte[3'(7 - bit_idx)] :
                       (mode == 1 && bit_idx == 4'd8) ? slave_ack : 1'b0;
    assign scl_ln = !(scl_oe || scl_hold);
    assign sda_ln = !(sda_oe || sda_hold || sda_slave);

    always @(posedge clk) begin
        cyc      <= cyc + 1;
        scl_prev <= scl_ln;
        sda_prev <= sda_ln;
        if (sda_prev && !sda_ln) t_sda_fall <= cyc;
        if (!sda_prev && sda_ln) t_sda_rise <= cyc;
        if (idx_clr) bit_idx <= 4'd0;
        else if (scl_prev && !scl_ln) begin
            t_scl_fall <= cyc;
            if (bit_idx == 4'd0) hi_bit0 <= cyc - t_rise;
            if (bit_idx == 4'd8) hi_ack  <= cyc - t_rise;
            if (mode != 0) bit_idx <= bit_idx + 4'd1;
        end
        if (!scl_prev && scl_ln) begin
            t_rise <= cyc;
            if (mode == 1 && bit_idx < 4'd8) cap <= {cap[6:0], sda_ln};
            if (mode == 2 && bit_idx == 4'd8) cap_ack <= sda_ln;
        end
    end

    task automatic summary_exit();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            bad = bad + 1;
            total = total + 1;
            summary_exit();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] code);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk("R12 done seen", int'(done), 1);
    endtask

    task automatic run_cmd(input logic [2:0] code);
        issue(code);
        wait_done();
    endtask

    task automatic set_slave(input int m);
        @(negedge clk);
        mode = m;
        idx_clr = 1'b1;
        @(negedge clk);
        idx_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 err", int'(err_code), 0);
        chk("R1 bus_ok", int'(bus_ok), 0);
        chk("R1 done", int'(done), 0);
    endtask

    task automatic t_ignore_codes();
        issue(3'd0);
        issue(3'd7);
        repeat (50) @(negedge clk);
        chk("R2 code0/7 busy", int'(busy), 0);
        chk("R2 code0/7 scl", int'(scl_oe), 0);
        chk("R2 code0/7 sda", int'(sda_oe), 0);
    endtask

    task automatic t_start();
        issue(3'd1);
        chk("R12 busy after accept", int'(busy), 1);
        wait_done();
        chk("R3 scl driven", int'(scl_oe), 1);
        chk("R3 sda driven", int'(sda_oe), 1);
        chk("R3 sda->scl gap", t_scl_fall - t_sda_fall, 6 * DIV);
        chk("R3 err", int'(err_code), 0);
        @(negedge clk);
        chk("R12 done one cycle", int'(done), 0);
    endtask

    task automatic t_write(input logic [7:0] b, input logic nack, input int exp_err);
        set_slave(1);
        slave_ack = !nack;
        wr_data = b;
        run_cmd(3'd3);
        chk("R5 byte on bus", int'(cap), int'(b));
        chk("R5 ack_out", int'(ack_out), int'(nack));
        chk("R5 err", int'(err_code), exp_err);
        chk("R7 tx high", hi_bit0, 9 * DIV);
        chk("R7 rx high", hi_ack, 6 * DIV);
        set_slave(0);
    endtask

    task automatic t_busy_ignore();
        set_slave(1);
        slave_ack = 1'b1;
        wr_data = 8'h3C;
        issue(3'd3);
        repeat (20) @(negedge clk);
        issue(3'd2);
        wait_done();
        repeat (300) @(negedge clk);
        chk("R2 busy cmd ignored byte", int'(cap), 8'h3C);
        chk("R2 busy cmd ignored scl", int'(scl_oe), 1);
        chk("R2 busy cmd ignored busy", int'(busy), 0);
        set_slave(0);
    endtask

    task automatic t_read(input logic [7:0] b, input logic a);
        set_slave(2);
        tx_byte = b;
        ack_in = a;
        run_cmd(3'd4);
        chk("R6 rd_data", int'(rd_data), int'(b));
        chk("R6 ack bit", int'(cap_ack), int'(a));
        chk("R6 sda parked", int'(sda_oe), int'(!a));
        set_slave(0);
    endtask

    task automatic t_sticky();
        scl_hold = 1'b1;
        wr_data = 8'h00;
        run_cmd(3'd3);
        scl_hold = 1'b0;
        chk("R10 first code kept", int'(err_code), 3);
        run_cmd(3'd6);
        @(negedge clk);
        chk("R10 cleared", int'(err_code), 0);
    endtask

    task automatic t_scl_stuck();
        scl_hold = 1'b1;
        wr_data = 8'h00;
        run_cmd(3'd3);
        scl_hold = 1'b0;
        chk("R8 scl held", int'(err_code), 1);
        run_cmd(3'd6);
    endtask

    task automatic t_sda_stuck();
        sda_hold = 1'b1;
        wr_data = 8'h80;
        run_cmd(3'd3);
        sda_hold = 1'b0;
        chk("R9 sda held", int'(err_code), 2);
        run_cmd(3'd6);
    endtask

    task automatic t_stop();
        sda_hold = 1'b1;
        run_cmd(3'd2);
        sda_hold = 1'b0;
        chk("R4 stop sda held", int'(err_code), 4);
        run_cmd(3'd6);
        run_cmd(3'd1);
        run_cmd(3'd2);
        chk("R4 stop err", int'(err_code), 0);
        chk("R4 scl released", int'(scl_oe), 0);
        chk("R4 sda released", int'(sda_oe), 0);
        chk("R4 rise gap", t_sda_rise - t_rise, 9 * DIV);
    endtask

    task automatic t_selftest();
        sda_hold = 1'b1;
        run_cmd(3'd5);
        sda_hold = 1'b0;
        chk("R11 fail bus_ok", int'(bus_ok), 0);
        chk("R11 fail err", int'(err_code), 4);
        run_cmd(3'd5);
        chk("R11 pass bus_ok", int'(bus_ok), 1);
        chk("R11 pass err cleared", int'(err_code), 0);
        chk("R11 pass scl", int'(scl_oe), 0);
        chk("R11 pass sda", int'(sda_oe), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_ignore_codes();
        t_start();
        t_write(8'hA5, 1'b0, 0);
        t_busy_ignore();
        t_read(8'h96, 1'b0);
        t_read(8'h5B, 1'b1);
        t_write(8'h12, 1'b1, 3);
        t_sticky();
        t_scl_stuck();
        t_sda_stuck();
        t_stop();
        t_selftest();
        summary_exit();
    end
endmodule